// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Controller

This block is the protocol engine of a byte-addressed serial memory that answers on a two-wire bus at one fixed 7-bit target address (binary 1010000). The bus clock and data lines are oversampled by a much faster system clock. Each line passes through a two-flop synchroniser and then an edge detector. From those edges the block decodes START, STOP and repeated START, and it shifts bytes in on SCL rising edges. It drives SDA only through an open-drain enable, and it changes that enable only after an SCL falling edge.

An internal byte-address register supports five transfers: byte write, page write, current-address read, random read and sequential read. Reads use a simple combinational read port into the array. Writes are handed over one byte at a time through a staging port into a page buffer owned by the back end. A single commit pulse on STOP tells the back end to program the buffered page. While the back end reports that a commit is in progress, the block answers its own address with a not-acknowledge, so a master can poll until the write is done. A write-protect input is sampled on the SCL falling edge that ends the word-address acknowledge. If it is high at that edge, the whole write is refused.

Top module: `ser_mem_target`

## Requirements
- R1: A byte after START is acknowledged only if its upper seven bits are 1010000. Bit 0 selects the direction: 1 is read, 0 is write. Any other value is not acknowledged, and later bytes are ignored up to the next START or STOP.
- R2: Without a preceding START (SDA falling while SCL is high), the block never pulls SDA low. STOP (SDA rising while SCL is high) returns it to idle from any state.
- R3: `sda_oe` changes only after an SCL falling edge, or when a START or STOP releases it. It never changes while SCL is high.
- R4: In a write, the block acknowledges the address byte, the word-address byte and each data byte. Each accepted data byte gives one `stg_we` pulse. A STOP after at least one accepted data byte gives exactly one `commit` pulse.
- R5: Consecutive data bytes of a write go to consecutive addresses within a 16-byte page. Only address bits 3:0 advance, so the address wraps inside the page; bits 7:4 are held.
- R6: While `busy_in` is high at the end of the address byte, that byte is not acknowledged and SDA stays released.
- R7: A write header, a word-address byte, a repeated START and a read header return the byte stored at the loaded word address.
- R8: In a read, a master acknowledge makes the block send the byte at the next address. The address wraps from 255 to 0. A master not-acknowledge ends the transfer.
- R9: A read that starts with no word address returns the byte at one past the last byte sent.
- R10: If write-protect is high at the SCL falling edge that ends the word-address acknowledge, the first data byte is not acknowledged. No byte is staged and no commit follows.
- R11: A STOP after only the address and word-address bytes loads the address register but gives no commit.
- R12: After reset, `sda_oe`, `stg_we` and `commit` are low and `rd_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line, as seen on the wire |
| wp_in | input | 1 | Write-protect request, high refuses writes |
| busy_in | input | 1 | Back end is committing a page |
| sda_oe | output | 1 | Pull SDA low when high |
| rd_addr | output | 8 | Read port address, equal to the address register |
| rd_data | input | 8 | Byte stored at `rd_addr` |
| stg_we | output | 1 | One-cycle pulse that stages one data byte |
| stg_first | output | 1 | Marks the first staged byte of a write; the back end clears its page buffer |
| stg_addr | output | 8 | Target address of the staged byte |
| stg_data | output | 8 | Staged byte |
| commit | output | 1 | One-cycle pulse that programs the staged page |

## Verification
Two conditions are hard to reach from the ports. The first is the no-acknowledge window while a commit is in progress. The bench back end raises `busy_in` for a fixed number of cycles after each `commit`. The master issues its address immediately after STOP, so the first poll always lands inside that window, and the retry count shows both the refusal and the later acceptance. The second is the write-protect sample edge. The bench raises write-protect before the word-address acknowledge ends, then checks that the first data byte is refused, that no commit is seen, and that the location still reads its old value.

// File: rtl/smt_pkg.sv
`timescale 1ns/1ps
package smt_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WORD,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_MACK,
        ST_IGNORE
    } st_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic is_rx_state(st_e s);
        return (s == ST_DEV) || (s == ST_WORD) || (s == ST_WDATA);
    endfunction

endpackage

// File: rtl/smt_bus_front.sv
`timescale 1ns/1ps
module smt_bus_front
    import smt_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    input  logic    wp_in,
    output bus_ev_t ev,
    output logic    wp_s
);

    localparam int CHAIN = SYNC_N + 1;

    logic [CHAIN-1:0] scl_q;
    logic [CHAIN-1:0] sda_q;
    logic [SYNC_N-1:0] wp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            wp_q  <= '0;
        end else begin
            scl_q <= {scl_q[CHAIN-2:0], scl_in};
            sda_q <= {sda_q[CHAIN-2:0], sda_in};
            wp_q  <= {wp_q[SYNC_N-2:0], wp_in};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_q[SYNC_N-1];
    assign scl_old = scl_q[SYNC_N];
    assign sda_now = sda_q[SYNC_N-1];
    assign sda_old = sda_q[SYNC_N];
    assign wp_s    = wp_q[SYNC_N-1];

    always_comb begin
        ev.scl_rise = scl_now & ~scl_old;
        ev.scl_fall = ~scl_now & scl_old;
        ev.start    = scl_now & scl_old & sda_old & ~sda_now;
        ev.stop     = scl_now & scl_old & ~sda_old & sda_now;
        ev.sda      = sda_now;
    end

endmodule

// File: rtl/smt_addr_reg.sv
`timescale 1ns/1ps
module smt_addr_reg #(
    parameter int AW = 8,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          inc_pg,
    input  logic          inc_all,
    output logic [AW-1:0] addr
);

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (ld)
            addr <= ld_val;
        else if (inc_pg)
            addr <= {addr[AW-1:PW], addr[PW-1:0] + 1'b1};
        else if (inc_all)
            addr <= addr + 1'b1;
    end

    // R5: a page-mode step never touches the page number
    a_r5_page_upper_held: assert property (@(posedge clk) disable iff (rst)
        (inc_pg && !ld) |=> addr[AW-1:PW] == $past(addr[AW-1:PW]));

    // R8: the read pointer rolls over from the top of the array to zero
    a_r8_full_wraps: assert property (@(posedge clk) disable iff (rst)
        (inc_all && !ld && !inc_pg && addr == {AW{1'b1}}) |=> addr == '0);

endmodule

// File: rtl/ser_mem_target.sv
`timescale 1ns/1ps
module ser_mem_target
    import smt_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter int          PAGE_W = 4,
    parameter int          SYNC_N = 2,
    parameter logic [6:0]  DEV_ID = 7'b1010000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              wp_in,
    input  logic              busy_in,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              stg_we,
    output logic              stg_first,
    output logic [ADDR_W-1:0] stg_addr,
    output logic [BYTE_W-1:0] stg_data,
    output logic              commit
);

    localparam logic [BIT_CNT_W-1:0] LAST_RX = BIT_CNT_W'(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] LAST_TX = BIT_CNT_W'(BYTE_W - 1);

    bus_ev_t ev;
    logic    wp_s;

    smt_bus_front #(.SYNC_N(SYNC_N)) u_front (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .wp_in  (wp_in),
        .ev     (ev),
        .wp_s   (wp_s)
    );

    st_e                  st, nxt;
    logic [BIT_CNT_W-1:0] cnt;
    logic [BYTE_W-1:0]    sh;
    logic                 oe;
    logic                 first;
    logic                 dirty;
    logic                 wp_lat;
    logic                 m_ack;
    logic [ADDR_W-1:0]    addr;

    // Byte boundary: eighth bit clocked, SCL now falling into the ack slot
    logic byte_end;
    logic data_ok;
    logic load_rd;
    logic a_ld, a_inc_pg;

    assign byte_end = ev.scl_fall && (cnt == LAST_RX) && is_rx_state(st);
    assign data_ok  = !(first && wp_lat);
    assign load_rd  = ev.scl_fall &&
                      (((st == ST_ACK) && (nxt == ST_RDATA)) || ((st == ST_MACK) && m_ack));
    assign a_ld     = byte_end && (st == ST_WORD);
    assign a_inc_pg = byte_end && (st == ST_WDATA) && data_ok;

    smt_addr_reg #(.AW(ADDR_W), .PW(PAGE_W)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .ld      (a_ld),
        .ld_val  (sh[ADDR_W-1:0]),
        .inc_pg  (a_inc_pg),
        .inc_all (load_rd),
        .addr    (addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            nxt       <= ST_IDLE;
            cnt       <= '0;
            sh        <= '0;
            oe        <= 1'b0;
            first     <= 1'b0;
            dirty     <= 1'b0;
            wp_lat    <= 1'b0;
            m_ack     <= 1'b0;
            stg_we    <= 1'b0;
            stg_first <= 1'b0;
            stg_addr  <= '0;
            stg_data  <= '0;
            commit    <= 1'b0;
        end else begin
            stg_we <= 1'b0;
            commit <= 1'b0;
            if (ev.stop) begin
                st     <= ST_IDLE;
                oe     <= 1'b0;
                commit <= dirty;
                dirty  <= 1'b0;
            end else if (ev.start) begin
                st    <= ST_DEV;
                cnt   <= '0;
                oe    <= 1'b0;
                dirty <= 1'b0;
            end else begin
                unique case (st)
                    ST_DEV, ST_WORD, ST_WDATA: begin
                        if (ev.scl_rise && cnt != LAST_RX) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (byte_end) begin
                            cnt <= '0;
                            if (st == ST_DEV) begin
                                if (sh[7:1] == DEV_ID && !busy_in) begin
                                    oe  <= 1'b1;
                                    st  <= ST_ACK;
                                    nxt <= sh[0] ? ST_RDATA : ST_WORD;
                                end else begin
                                    st <= ST_IGNORE;
                                end
                            end else if (st == ST_WORD) begin
                                oe    <= 1'b1;
                                st    <= ST_ACK;
                                nxt   <= ST_WDATA;
                                first <= 1'b1;
                            end else if (data_ok) begin
                                oe        <= 1'b1;
                                st        <= ST_ACK;
                                nxt       <= ST_WDATA;
                                stg_we    <= 1'b1;
                                stg_first <= first;
                                stg_addr  <= addr;
                                stg_data  <= sh;
                                dirty     <= 1'b1;
                                first     <= 1'b0;
                            end else begin
                                st <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            oe  <= 1'b0;
                            st  <= nxt;
                            cnt <= '0;
                            if (first)
                                wp_lat <= wp_s;
                            if (nxt == ST_RDATA) begin
                                sh <= rd_data;
                                oe <= ~rd_data[BYTE_W-1];
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_fall) begin
                            if (cnt == LAST_TX) begin
                                oe  <= 1'b0;
                                st  <= ST_MACK;
                                cnt <= '0;
                            end else begin
                                sh  <= {sh[BYTE_W-2:0], 1'b0};
                                oe  <= ~sh[BYTE_W-2];
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev.scl_rise) begin
                            m_ack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (m_ack) begin
                                st  <= ST_RDATA;
                                sh  <= rd_data;
                                oe  <= ~rd_data[BYTE_W-1];
                                cnt <= '0;
                            end else begin
                                st <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe  = oe;
    assign rd_addr = addr;

    // R3: the data line moves only after a clock fall or a bus condition
    a_r3_oe_after_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe) |-> $past(ev.scl_fall || ev.start || ev.stop));

    // R6: an address byte ending while busy leaves SDA released
    a_r6_busy_no_ack: assert property (@(posedge clk) disable iff (rst)
        (byte_end && st == ST_DEV && busy_in) |=> !sda_oe);

    // R4: a commit pulse follows only a STOP
    a_r4_commit_on_stop: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(ev.stop));

    // R10: the opening byte of a write is never staged under protection
    a_r10_wp_blocks_stage: assert property (@(posedge clk) disable iff (rst)
        (stg_we && stg_first) |-> !wp_lat);

endmodule

// File: tb/sim_ser_mem_target.sv
`timescale 1ns/1ps
module sim_ser_mem_target;

    localparam int Q    = 8;
    localparam int BUSY = 300;
    localparam int NV   = 6;
    localparam logic [15:0] VEC [NV] = '{
        16'h00_3C, 16'h7F_A5, 16'hFF_01, 16'h10_FE, 16'h55_00, 16'hA0_5A
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1, wp_m = 1'b0;
    logic sda_oe, stg_we, stg_first, commit, busy_in;
    logic [7:0] rd_addr, rd_data, stg_addr, stg_data;
    logic sda_bus;

    int checks = 0, fails = 0, commits = 0, busy_cnt = 0, r3_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;
    assign busy_in = (busy_cnt != 0);

    ser_mem_target u0 (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus), .wp_in(wp_m),
        .busy_in(busy_in), .sda_oe(sda_oe), .rd_addr(rd_addr), .rd_data(rd_data),
        .stg_we(stg_we), .stg_first(stg_first), .stg_addr(stg_addr),
        .stg_data(stg_data), .commit(commit)
    );

    function automatic logic [7:0] f_init(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    // back end: array, page buffer and commit timer
    logic [7:0] mem [256];
    logic [7:0] pbuf [16];
    logic       pval [16];
    logic [3:0] pg_hi;

    assign rd_data = mem[rd_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 256; k++) mem[k] <= f_init(k);
            for (int k = 0; k < 16; k++) pval[k] <= 1'b0;
            busy_cnt <= 0;
            pg_hi <= '0;
        end else begin
            if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
            if (stg_we) begin
                for (int k = 0; k < 16; k++) if (stg_first) pval[k] <= 1'b0;
                pval[stg_addr[3:0]] <= 1'b1;
                pbuf[stg_addr[3:0]] <= stg_data;
                pg_hi <= stg_addr[7:4];
            end
            if (commit) begin
                for (int k = 0; k < 16; k++) begin
                    if (pval[k]) mem[{pg_hi, 4'(k)}] <= pbuf[k];
                    pval[k] <= 1'b0;
                end
                busy_cnt <= BUSY;
                commits  <= commits + 1;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_cycle(input logic drv, output logic seen);
        logic oe_a;
        sda_m = drv;
        tick(Q);
        scl_m = 1'b1;
        tick(1);
        oe_a = sda_oe;
        tick(Q - 2);
        seen = sda_bus;
        if (sda_oe !== oe_a) r3_bad++;
        tick(1);
        scl_m = 1'b0;
        tick(2);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        bit_cycle(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, s);
            b[i] = s;
        end
        bit_cycle(~mack, s);
    endtask

    // repeat the write header until acknowledged; returns attempts used
    task automatic poll_dev(output int tries);
        logic a;
        tries = 0;
        do begin
            tries++;
            bus_start();
            send_byte(8'hA0, a);
            if (!a) bus_stop();
        end while (!a && tries < 50);
    endtask

    task automatic rand_read_after_poll(input logic [7:0] wa, output logic [7:0] d);
        logic a;
        send_byte(wa, a);
        bus_start();
        send_byte(8'hA1, a);
        recv_byte(d, 1'b0);
        bus_stop();
    endtask

    initial begin
        logic a0, a1, a2;
        logic [7:0] d, d1, d2;
        int tries, c0;

        tick(10);
        // R12: reset values
        chk(sda_oe == 1'b0, "R12 sda_oe", sda_oe, 0);
        chk(rd_addr == 8'h00, "R12 rd_addr", rd_addr, 0);
        chk(commit == 1'b0 && stg_we == 1'b0, "R12 strobes", {commit, stg_we}, 0);
        rst = 1'b0;
        tick(10);

        // R2: a matching byte with no START draws no acknowledge
        send_byte(8'hA0, a0);
        chk(!a0, "R2 no START no ack", a0, 0);

        // R1: foreign address refused, following byte ignored
        bus_start();
        send_byte(8'hA2, a0);
        send_byte(8'h00, a1);
        bus_stop();
        chk(!a0, "R1 foreign address", a0, 0);
        chk(!a1, "R1 byte after refusal", a1, 0);

        // R4/R6/R7: vector table of byte writes and random reads
        for (int v = 0; v < NV; v++) begin
            c0 = commits;
            bus_start();
            send_byte(8'hA0, a0);
            send_byte(VEC[v][15:8], a1);
            send_byte(VEC[v][7:0], a2);
            bus_stop();
            tick(2);
            chk(a0 && a1 && a2, "R4 write acks", {a0, a1, a2}, 3'b111);
            chk(commits == c0 + 1, "R4 one commit", commits, c0 + 1);
            poll_dev(tries);
            chk(tries > 1 && tries < 50, "R6 busy refuses address", tries, 2);
            rand_read_after_poll(VEC[v][15:8], d);
            chk(d == VEC[v][7:0], "R7 random read", d, VEC[v][7:0]);
        end

        // R11: address-only write loads pointer, no commit
        c0 = commits;
        bus_start();
        send_byte(8'hA0, a0);
        send_byte(8'h20, a1);
        bus_stop();
        tick(4);
        chk(commits == c0, "R11 no commit", commits, c0);
        bus_start();
        send_byte(8'hA1, a0);
        chk(a0, "R11 not busy after", a0, 1);
        recv_byte(d, 1'b0);
        bus_stop();
        chk(d == f_init(8'h20), "R11 pointer loaded", d, f_init(8'h20));

        // R8: sequential read across the top of the array
        poll_dev(tries);
        send_byte(8'hFE, a1);
        bus_start();
        send_byte(8'hA1, a0);
        recv_byte(d, 1'b1);
        recv_byte(d1, 1'b1);
        recv_byte(d2, 1'b0);
        bus_stop();
        chk(d == f_init(8'hFE), "R8 first byte", d, f_init(8'hFE));
        chk(d1 == 8'h01, "R8 top byte", d1, 8'h01);
        chk(d2 == 8'h3C, "R8 wrapped to zero", d2, 8'h3C);

        // R9: current-address read continues after the last byte sent
        bus_start();
        send_byte(8'hA1, a0);
        recv_byte(d, 1'b0);
        bus_stop();
        chk(d == f_init(1), "R9 current address", d, f_init(1));

        // R5: page write wraps inside its 16-byte page
        bus_start();
        send_byte(8'hA0, a0);
        send_byte(8'h3E, a1);
        send_byte(8'h11, a2);
        send_byte(8'h22, a2);
        send_byte(8'h33, a2);
        send_byte(8'h44, a2);
        bus_stop();
        poll_dev(tries);
        send_byte(8'h30, a1);
        bus_start();
        send_byte(8'hA1, a0);
        recv_byte(d, 1'b1);
        recv_byte(d1, 1'b1);
        recv_byte(d2, 1'b1);
        recv_byte(d2, 1'b0);
        bus_stop();
        chk(d == 8'h33, "R5 wrapped byte at page start", d, 8'h33);
        chk(d1 == 8'h44, "R5 next wrapped byte", d1, 8'h44);
        chk(d2 == f_init(8'h33), "R5 untouched inside page", d2, f_init(8'h33));
        poll_dev(tries);
        rand_read_after_poll(8'h3F, d);
        chk(d == 8'h22, "R5 last byte of page", d, 8'h22);
        poll_dev(tries);
        rand_read_after_poll(8'h40, d);
        chk(d == f_init(8'h40), "R5 next page untouched", d, f_init(8'h40));

        // R10: write-protect high at the sample edge refuses the write
        wp_m = 1'b1;
        c0 = commits;
        bus_start();
        send_byte(8'hA0, a0);
        send_byte(8'h60, a1);
        send_byte(8'h99, a2);
        bus_stop();
        wp_m = 1'b0;
        tick(4);
        chk(a0 && a1, "R10 header acked", {a0, a1}, 2'b11);
        chk(!a2, "R10 data refused", a2, 0);
        chk(commits == c0, "R10 no commit", commits, c0);
        poll_dev(tries);
        chk(tries == 1, "R10 not busy", tries, 1);
        rand_read_after_poll(8'h60, d);
        chk(d == f_init(8'h60), "R10 data kept", d, f_init(8'h60));

        // R3: no enable change seen during any SCL high phase
        chk(r3_bad == 0, "R3 stable while SCL high", r3_bad, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule